// File: doc/BRIEF.md
# Chained Serial Setup Loader

This block keeps a device's setup word in a serial shift register that is filled one bit at a time from a serial input. Several devices are wired in a line. Each device's serial output drives the serial input of the next device, and the serial output of the last device is left open. One bit stream loads the whole line.

While its own word is still being filled, the device holds its serial output at 0 and its busy flag high. The busy flag drops right after the last bit of the word has been captured. From then on, the device no longer shifts. It passes its serial input combinationally to its serial output, so the bits that follow reach the devices further down the line. The parallel setup word then stays frozen until the next reset. Requests to select a queue are masked until loading has finished.

Top module: `cfg_chain_loader`

## Requirements
- R1: While `rst_n` is low and right after it rises, `cfg_busy` is 1, `cfg_word` is all zeros and the bit count starts from zero.
- R2: `cfg_busy` stays 1 through the first CFG_BITS-1 rising edges at which `ser_load` is 1. It drops to 0 right after the CFG_BITS-th such edge and not at any earlier edge.
- R3: At each rising edge where `ser_load` is 1 during loading, `cfg_word` shifts right by one and `ser_in` enters at bit CFG_BITS-1, so the first bit received ends at bit 0 (least significant bit first). Edges where `ser_load` is 0 leave `cfg_word` unchanged, whatever `ser_in` is.
- R4: While `cfg_busy` is 1, `ser_out` is 0 for any value of `ser_in`.
- R5: Once `cfg_busy` is 0, `ser_out` equals `ser_in` in the same cycle, with no register in between.
- R6: `sel_allow` is 0 while `cfg_busy` is 1. Once `cfg_busy` is 0, `sel_allow` equals `sel_req`.
- R7: After `cfg_busy` has gone to 0, `cfg_word` and `cfg_busy` stay unchanged whatever happens on `ser_load` and `ser_in`, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial setup data, least significant bit first |
| ser_load | input | 1 | Load strobe: a bit is taken at each rising edge while this is 1 |
| sel_req | input | 1 | Queue-select request from the user side |
| ser_out | output | 1 | Serial output to the next device: 0 while loading, a copy of `ser_in` afterwards |
| cfg_busy | output | 1 | 1 while loading is in progress, 0 once the word is complete |
| sel_allow | output | 1 | Queue-select request after masking by the loading state |
| cfg_word | output | CFG_BITS | Parallel setup word |

## Verification
The capture of the last bit and the switch to pass-through, together with the release of the select mask, all take place at one clock edge. The bench holds `sel_req` high and sets `ser_in` to the last bit while that bit is loaded. Before the edge it expects `ser_out` and `sel_allow` to be 0. After the edge it expects the last bit to be in bit CFG_BITS-1, `ser_out` to follow `ser_in` at once, and `sel_allow` to be 1. Further strobes are then sent to confirm that the frozen word does not take in any of the bits passed on down the line.

// File: rtl/cfg_chain_pkg.sv
`timescale 1ns/1ps
package cfg_chain_pkg;

    parameter int unsigned CFG_BITS_DEFAULT = 16;

    typedef enum logic {
        PH_LOADING = 1'b0,
        PH_PASSING = 1'b1
    } phase_e;

    function automatic int unsigned cnt_width(input int unsigned nbits);
        return $clog2(nbits + 1);
    endfunction

endpackage

// File: rtl/cfg_bit_counter.sv
`timescale 1ns/1ps
module cfg_bit_counter
    import cfg_chain_pkg::*;
#(
    parameter int unsigned CFG_BITS = CFG_BITS_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_req,
    output logic shift_en,
    output logic busy
);
    localparam int unsigned CW = cnt_width(CFG_BITS);
    localparam logic [CW-1:0] LAST_IDX = CW'(CFG_BITS - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(CFG_BITS);

    typedef struct packed {
        phase_e          phase;
        logic [CW-1:0]   cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        shift_en = shift_req && (st_q.phase == PH_LOADING);
        if (shift_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_IDX) begin
                st_d.phase = PH_PASSING;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_LOADING, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase == PH_LOADING);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT); // R2
    AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> st_q.cnt == FULL_CNT); // R2
    AST_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(shift_req)); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy); // R7

endmodule

// File: rtl/cfg_shift_reg.sv
`timescale 1ns/1ps
module cfg_shift_reg
    import cfg_chain_pkg::*;
#(
    parameter int unsigned CFG_BITS = CFG_BITS_DEFAULT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                bit_in,
    output logic [CFG_BITS-1:0] word
);
    typedef struct packed {
        logic [CFG_BITS-1:0] word;
    } sr_state_t;

    sr_state_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) begin
            if (CFG_BITS > 1) begin
                sr_d.word = {bit_in, sr_q.word[CFG_BITS-1:1]};
            end else begin
                sr_d.word = CFG_BITS'(bit_in);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign word = sr_q.word;

    AST_HOLD_WITHOUT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word)); // R3
    AST_MSB_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> word[CFG_BITS-1] == $past(bit_in)); // R3

endmodule

// File: rtl/cfg_chain_route.sv
`timescale 1ns/1ps
module cfg_chain_route (
    input  logic busy,
    input  logic ser_in,
    input  logic sel_req,
    output logic ser_out,
    output logic sel_allow
);
    always_comb begin
        ser_out   = 1'b0;
        sel_allow = 1'b0;
        if (!busy) begin
            ser_out   = ser_in;
            sel_allow = sel_req;
        end
    end

    always_comb begin
        if (busy) begin
            AST_ROUTE_QUIET: assert (!ser_out && !sel_allow); // R4
        end
    end

endmodule

// File: rtl/cfg_chain_loader.sv
`timescale 1ns/1ps
module cfg_chain_loader
    import cfg_chain_pkg::*;
#(
    parameter int unsigned CFG_BITS = CFG_BITS_DEFAULT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic                ser_load,
    input  logic                sel_req,
    output logic                ser_out,
    output logic                cfg_busy,
    output logic                sel_allow,
    output logic [CFG_BITS-1:0] cfg_word
);
    logic shift_en;
    logic busy;

    cfg_bit_counter #(.CFG_BITS(CFG_BITS)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_req (ser_load),
        .shift_en  (shift_en),
        .busy      (busy)
    );

    cfg_shift_reg #(.CFG_BITS(CFG_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (ser_in),
        .word     (cfg_word)
    );

    cfg_chain_route u_route (
        .busy      (busy),
        .ser_in    (ser_in),
        .sel_req   (sel_req),
        .ser_out   (ser_out),
        .sel_allow (sel_allow)
    );

    assign cfg_busy = busy;

    AST_OUT_QUIET_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_busy |-> !ser_out); // R4
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_busy |-> ser_out == ser_in); // R5
    AST_SEL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_busy |-> !sel_allow); // R6
    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_busy |=> $stable(cfg_word)); // R7

endmodule

// File: tb/test_cfg_chain_loader.sv
`timescale 1ns/1ps
module test_cfg_chain_loader;
    localparam int unsigned N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_in = 1'b0;
    logic         ser_load = 1'b0;
    logic         sel_req = 1'b0;
    logic         ser_out;
    logic         cfg_busy;
    logic         sel_allow;
    logic [N-1:0] cfg_word;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [N-1:0] word;
        string        tag;
    } exp_t;
    exp_t exp_q[$];
    event word_ev;

    always #10 clk = ~clk;

    cfg_chain_loader #(.CFG_BITS(N)) i_cfg_chain_loader (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_load(ser_load),
        .sel_req(sel_req), .ser_out(ser_out), .cfg_busy(cfg_busy),
        .sel_allow(sel_allow), .cfg_word(cfg_word)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares the parallel word against queued expectations
    initial begin
        forever begin
            @(word_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cfg_word == e.word, e.tag, 32'(cfg_word), 32'(e.word));
            end
        end
    end

    task automatic expect_word(input logic [N-1:0] w, input string tag);
        exp_q.push_back('{word: w, tag: tag});
        ->word_ev;
        #0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ser_load = 1'b0; ser_in = 1'b1; sel_req = 1'b1;
        #1;
        chk(cfg_busy == 1'b1, "R1 busy in reset", 32'(cfg_busy), 1);
        expect_word('0, "R1 word in reset");
        chk(ser_out == 1'b0, "R4 out in reset", 32'(ser_out), 0);
        chk(sel_allow == 1'b0, "R6 sel in reset", 32'(sel_allow), 0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1; sel_req = 1'b0; ser_in = 1'b0;
    endtask

    // Loads nbits of v starting at bit 0; with gap, inserts an idle edge
    // with toggled data between bits (R3 ignore check).
    task automatic load_bits(input logic [N-1:0] v, input int nbits, input bit gap);
        for (int i = 0; i < nbits; i++) begin
            ser_in = v[i]; ser_load = 1'b1; sel_req = 1'b1;
            #1;
            chk(cfg_busy == 1'b1, "R2 busy before last bit", 32'(cfg_busy), 1);
            chk(ser_out == 1'b0, "R4 out quiet while loading", 32'(ser_out), 0);
            chk(sel_allow == 1'b0, "R6 sel masked while loading", 32'(sel_allow), 0);
            @(negedge clk);
            if (gap && i < nbits - 1) begin
                ser_load = 1'b0; ser_in = ~v[i];
                @(negedge clk);
            end
        end
        ser_load = 1'b0;
        #1;
    endtask

    task automatic full_load(input logic [N-1:0] v, input bit gap, input string tag);
        load_bits(v, N, gap);
        chk(cfg_busy == 1'b0, "R2 busy falls after last bit", 32'(cfg_busy), 0);
        chk(sel_allow == 1'b1, "R6 sel released with last bit", 32'(sel_allow), 1);
        expect_word(v, tag);
    endtask

    task automatic check_pass();
        for (int b = 0; b < 2; b++) begin
            ser_in = b[0];
            #1;
            chk(ser_out == b[0], "R5 pass-through", 32'(ser_out), 32'(b));
            sel_req = b[0];
            #1;
            chk(sel_allow == b[0], "R6 sel follows req", 32'(sel_allow), 32'(b));
        end
    endtask

    task automatic check_frozen(input logic [N-1:0] v);
        for (int i = 0; i < 5; i++) begin
            ser_load = 1'b1; ser_in = i[0];
            @(negedge clk);
            #1;
            chk(cfg_busy == 1'b0, "R7 busy stays low", 32'(cfg_busy), 0);
        end
        ser_load = 1'b0;
        expect_word(v, "R7 word frozen");
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] v1, v2;
        v1 = 16'hA5C3;
        v2 = 16'h1E7F;
        do_reset();
        // R3: partial load of three bits lands in the top bits, LSB first
        load_bits(v1, 3, 1'b1);
        expect_word({v1[2:0], 13'b0}, "R3 partial shift LSB first");
        // R1: reset mid-load clears the partial word
        do_reset();
        @(negedge clk);
        #1;
        expect_word('0, "R1 word after reset");
        chk(cfg_busy == 1'b1, "R1 busy after reset", 32'(cfg_busy), 1);
        // Full load with idle gaps, then pass-through and freeze
        full_load(v1, 1'b1, "R3 full word with gaps");
        check_pass();
        check_frozen(v1);
        // Second pattern, back-to-back strobes
        do_reset();
        full_load(v2, 1'b0, "R3 full word back-to-back");
        chk(cfg_word[N-1] == v2[N-1], "R3 last bit in msb", 32'(cfg_word[N-1]), 32'(v2[N-1]));
        check_pass();
        check_frozen(v2);
        // All-ones pattern
        do_reset();
        full_load('1, 1'b0, "R3 all ones");
        check_frozen('1);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule